// File: doc/BRIEF.md
# Trace Segment Store with Hit Logic and Line Fill

This block keeps a small direct-mapped store of trace segments. A trace segment is a run of retired instructions laid out in dynamic execution order: it spans at most `N_INSN` instructions and at most `M_BR` basic blocks, where the conditional branches close the basic blocks. The front end uses it to fetch across branches in a single access. A lookup presents a fetch address and a vector of predicted branch directions. If the selected entry holds a segment that starts at that address and follows the same path, the block returns the whole segment, its instruction count, its fall-through and target addresses, and whether it ends on a conditional branch.

The fill side watches the retirement stream, one instruction per cycle with a valid strobe. It gathers instructions in a line-fill buffer. When the buffer holds `N_INSN` instructions, or when the `M_BR`-th conditional branch arrives, whichever comes first, it writes the segment into the entry that the start address selects. A new segment then begins with the next retired instruction. The path of a segment is recorded as one direction bit for each internal conditional branch, and a mask records how many of those bits count.

Top module: `trace_seg_cache`

## Requirements
- R1: While reset is held, and after it, every entry is empty. A lookup misses until a segment has been written to the entry that the lookup address selects.
- R2: On a miss, lk_count, lk_insns, lk_fallthru, lk_target and lk_ends_cond are all zero.
- R3: A segment is closed and written on the retire cycle that brings its instruction count to N_INSN. A hit then returns that count and the instructions in retirement order: slot k sits at lk_insns bits [k*INSN_W +: INSN_W], and slots beyond the count read zero.
- R4: A segment is closed early on the retire cycle that delivers the M_BR-th conditional branch. It then reports lk_ends_cond=1, lk_fallthru equal to that branch's address plus one, and lk_target equal to that branch's rt_target.
- R5: A segment whose last instruction is not a conditional branch reports lk_ends_cond=0, with lk_target and lk_fallthru both equal to the last instruction's address plus one.
- R6: A hit requires the lookup address to equal the full start address of the stored segment. Another address that selects the same entry misses.
- R7: Bit i of lk_pred (bit 0 is the oldest) is compared with the taken direction of the i-th internal conditional branch. Only as many bits as the segment has internal branches are compared. A mismatch in a compared bit misses. Bits above that count have no effect on the outcome.
- R8: After a write the line-fill buffer is empty, so the next retired instruction becomes the start of the next segment.
- R9: The entry index is the low IDX_W bits of an address. A write replaces whatever the selected entry held.
- R10: A lookup in the same cycle as a write to the same entry sees the entry's contents from before the write. The new segment is visible from the next cycle on.
- R11: With lk_req low, lk_hit is 0.
- R12: Cycles with rt_valid low add nothing to the line-fill buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Fetch address of the lookup |
| lk_pred | input | M_BR-1 | Predicted directions, bit 0 for the oldest branch, 1 = taken |
| lk_hit | output | 1 | Segment hit |
| lk_count | output | $clog2(N_INSN+1) | Instructions in the hit segment |
| lk_insns | output | N_INSN*INSN_W | Segment instructions, slot 0 in the low bits |
| lk_ends_cond | output | 1 | The segment ends on a conditional branch |
| lk_fallthru | output | ADDR_W | Address after the last instruction |
| lk_target | output | ADDR_W | Target of the final branch, or the fall-through address |
| rt_valid | input | 1 | A retired instruction is presented |
| rt_insn | input | INSN_W | Retired instruction word |
| rt_addr | input | ADDR_W | Address of the retired instruction |
| rt_is_cond | input | 1 | The retired instruction is a conditional branch |
| rt_taken | input | 1 | Resolved direction of that branch |
| rt_target | input | ADDR_W | Taken target of that branch |

## Verification
The bench builds the block with eight-instruction segments, three branches per segment and four entries. With these values, both closing rules, a segment that ends on a branch by count alone, and the masking of the unused upper prediction bit can all be reached within a few dozen retirements. With only four entries, aliasing between addresses that share low bits and overwriting of a live entry happen almost at once. Lookups are timed against the closing retirement to expose the read-before-write ordering. A reset in the middle of a fill shows that a partly filled buffer is discarded.

// File: rtl/tc_pkg.sv
package tc_pkg;

  // Width of a counter that must hold the values 0..n inclusive.
  function automatic int unsigned tc_cnt_w(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/tc_rst_sync.sv
module tc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;

endmodule

// File: rtl/tc_fill_unit.sv
module tc_fill_unit #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned INSN_W = 32,
  parameter int unsigned N_INSN = 8,
  parameter int unsigned M_BR   = 3,
  parameter int unsigned IDX_W  = 2,
  localparam int unsigned CNT_W = tc_pkg::tc_cnt_w(N_INSN),
  localparam int unsigned BRC_W = tc_pkg::tc_cnt_w(M_BR),
  localparam int unsigned FL_W  = M_BR - 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rt_valid,
  input  logic [INSN_W-1:0]        rt_insn,
  input  logic [ADDR_W-1:0]        rt_addr,
  input  logic                     rt_is_cond,
  input  logic                     rt_taken,
  input  logic [ADDR_W-1:0]        rt_target,
  output logic                     wr_en,
  output logic [IDX_W-1:0]         wr_idx,
  output logic [ADDR_W-1:0]        wr_tag,
  output logic [N_INSN*INSN_W-1:0] wr_insns,
  output logic [CNT_W-1:0]         wr_cnt,
  output logic [FL_W-1:0]          wr_mask,
  output logic [FL_W-1:0]          wr_flags,
  output logic                     wr_end_cond,
  output logic [ADDR_W-1:0]        wr_fallthru,
  output logic [ADDR_W-1:0]        wr_target
);

  // fill state
  logic [CNT_W-1:0]  cnt_q,   cnt_d;
  logic [BRC_W-1:0]  brs_q,   brs_d;
  logic [FL_W-1:0]   flags_q, flags_d;
  logic [ADDR_W-1:0] start_q;
  logic [INSN_W-1:0] buf_q [N_INSN];

  logic [CNT_W-1:0]  cnt_inc;
  logic [BRC_W-1:0]  brs_inc;
  logic              close;
  logic              state_en;
  logic              start_en;
  logic [N_INSN-1:0] buf_we;
  logic [ADDR_W-1:0] seg_start;
  logic [ADDR_W-1:0] next_addr;

  assign cnt_inc   = cnt_q + CNT_W'(1);
  assign brs_inc   = brs_q + BRC_W'(rt_is_cond);
  assign close     = rt_valid && ((cnt_inc == CNT_W'(N_INSN)) || (brs_inc == BRC_W'(M_BR)));
  assign state_en  = rt_valid;
  assign start_en  = rt_valid && (cnt_q == '0);
  assign seg_start = (cnt_q == '0) ? rt_addr : start_q;
  assign next_addr = rt_addr + ADDR_W'(1);

  // next-state logic
  always_comb begin
    cnt_d   = cnt_q;
    brs_d   = brs_q;
    flags_d = flags_q;
    if (close) begin
      cnt_d   = '0;
      brs_d   = '0;
      flags_d = '0;
    end else if (rt_valid) begin
      cnt_d = cnt_inc;
      brs_d = brs_inc;
      for (int i = 0; i < int'(FL_W); i++) begin
        if (rt_is_cond && (brs_q == BRC_W'(i))) flags_d[i] = rt_taken;
      end
    end
  end

  // buffer slot enables and the segment image handed to the store
  for (genvar j = 0; j < int'(N_INSN); j++) begin : g_slot
    assign buf_we[j] = rt_valid && !close && (cnt_q == CNT_W'(j));
    assign wr_insns[j*INSN_W +: INSN_W] =
      (CNT_W'(j) < cnt_q)  ? buf_q[j] :
      (CNT_W'(j) == cnt_q) ? rt_insn  : '0;
  end

  // one mask bit per branch already held before the closing instruction
  for (genvar i = 0; i < int'(FL_W); i++) begin : g_mask
    assign wr_mask[i] = (BRC_W'(i) < brs_q);
  end

  assign wr_en       = close;
  assign wr_tag      = seg_start;
  assign wr_idx      = seg_start[IDX_W-1:0];
  assign wr_cnt      = cnt_inc;
  assign wr_flags    = flags_q;
  assign wr_end_cond = rt_is_cond;
  assign wr_fallthru = next_addr;
  assign wr_target   = rt_is_cond ? rt_target : next_addr;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      brs_q   <= '0;
      flags_q <= '0;
    end else if (state_en) begin
      cnt_q   <= cnt_d;
      brs_q   <= brs_d;
      flags_q <= flags_d;
    end
  end

  always_ff @(posedge clk) begin
    if (start_en) start_q <= rt_addr;
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < int'(N_INSN); j++) begin
      if (buf_we[j]) buf_q[j] <= rt_insn;
    end
  end

endmodule

// File: rtl/tc_seg_store.sv
module tc_seg_store #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned INSN_W = 32,
  parameter int unsigned N_INSN = 8,
  parameter int unsigned M_BR   = 3,
  parameter int unsigned IDX_W  = 2,
  localparam int unsigned CNT_W   = tc_pkg::tc_cnt_w(N_INSN),
  localparam int unsigned FL_W    = M_BR - 1,
  localparam int unsigned ENTRIES = 1 << IDX_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [ADDR_W-1:0]        wr_tag,
  input  logic [N_INSN*INSN_W-1:0] wr_insns,
  input  logic [CNT_W-1:0]         wr_cnt,
  input  logic [FL_W-1:0]          wr_mask,
  input  logic [FL_W-1:0]          wr_flags,
  input  logic                     wr_end_cond,
  input  logic [ADDR_W-1:0]        wr_fallthru,
  input  logic [ADDR_W-1:0]        wr_target,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic                     rd_valid,
  output logic [ADDR_W-1:0]        rd_tag,
  output logic [N_INSN*INSN_W-1:0] rd_insns,
  output logic [CNT_W-1:0]         rd_cnt,
  output logic [FL_W-1:0]          rd_mask,
  output logic [FL_W-1:0]          rd_flags,
  output logic                     rd_end_cond,
  output logic [ADDR_W-1:0]        rd_fallthru,
  output logic [ADDR_W-1:0]        rd_target
);

  logic [ENTRIES-1:0]        valid_q;
  logic [ENTRIES-1:0]        ent_we;
  logic [ADDR_W-1:0]         tag_q   [ENTRIES];
  logic [N_INSN*INSN_W-1:0]  insns_q [ENTRIES];
  logic [CNT_W-1:0]          cnt_q   [ENTRIES];
  logic [FL_W-1:0]           mask_q  [ENTRIES];
  logic [FL_W-1:0]           flags_q [ENTRIES];
  logic                      endc_q  [ENTRIES];
  logic [ADDR_W-1:0]         ft_q    [ENTRIES];
  logic [ADDR_W-1:0]         tgt_q   [ENTRIES];

  for (genvar e = 0; e < int'(ENTRIES); e++) begin : g_we
    assign ent_we[e] = wr_en && (wr_idx == IDX_W'(e));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      for (int e = 0; e < int'(ENTRIES); e++) begin
        if (ent_we[e]) valid_q[e] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < int'(ENTRIES); e++) begin
      if (ent_we[e]) begin
        tag_q[e]   <= wr_tag;
        insns_q[e] <= wr_insns;
        cnt_q[e]   <= wr_cnt;
        mask_q[e]  <= wr_mask;
        flags_q[e] <= wr_flags;
        endc_q[e]  <= wr_end_cond;
        ft_q[e]    <= wr_fallthru;
        tgt_q[e]   <= wr_target;
      end
    end
  end

  // read port: the registers as they stand, so a write in the same cycle is not seen
  assign rd_valid    = valid_q[rd_idx];
  assign rd_tag      = tag_q[rd_idx];
  assign rd_insns    = insns_q[rd_idx];
  assign rd_cnt      = cnt_q[rd_idx];
  assign rd_mask     = mask_q[rd_idx];
  assign rd_flags    = flags_q[rd_idx];
  assign rd_end_cond = endc_q[rd_idx];
  assign rd_fallthru = ft_q[rd_idx];
  assign rd_target   = tgt_q[rd_idx];

endmodule

// File: rtl/tc_hit_logic.sv
module tc_hit_logic #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned INSN_W = 32,
  parameter int unsigned N_INSN = 8,
  parameter int unsigned M_BR   = 3,
  localparam int unsigned CNT_W = tc_pkg::tc_cnt_w(N_INSN),
  localparam int unsigned FL_W  = M_BR - 1
) (
  input  logic                     lk_req,
  input  logic [ADDR_W-1:0]        lk_addr,
  input  logic [FL_W-1:0]          lk_pred,
  input  logic                     rd_valid,
  input  logic [ADDR_W-1:0]        rd_tag,
  input  logic [N_INSN*INSN_W-1:0] rd_insns,
  input  logic [CNT_W-1:0]         rd_cnt,
  input  logic [FL_W-1:0]          rd_mask,
  input  logic [FL_W-1:0]          rd_flags,
  input  logic                     rd_end_cond,
  input  logic [ADDR_W-1:0]        rd_fallthru,
  input  logic [ADDR_W-1:0]        rd_target,
  output logic                     hit,
  output logic [CNT_W-1:0]         out_cnt,
  output logic [N_INSN*INSN_W-1:0] out_insns,
  output logic                     out_end_cond,
  output logic [ADDR_W-1:0]        out_fallthru,
  output logic [ADDR_W-1:0]        out_target
);

  logic tag_eq;
  logic path_eq;

  assign tag_eq  = (rd_tag == lk_addr);
  assign path_eq = (((lk_pred ^ rd_flags) & rd_mask) == '0);
  assign hit     = lk_req && rd_valid && tag_eq && path_eq;

  assign out_cnt      = hit ? rd_cnt      : '0;
  assign out_insns    = hit ? rd_insns    : '0;
  assign out_end_cond = hit && rd_end_cond;
  assign out_fallthru = hit ? rd_fallthru : '0;
  assign out_target   = hit ? rd_target   : '0;

endmodule

// File: rtl/trace_seg_cache.sv
module trace_seg_cache #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned INSN_W = 32,
  parameter int unsigned N_INSN = 8,
  parameter int unsigned M_BR   = 3,
  parameter int unsigned IDX_W  = 2,
  localparam int unsigned CNT_W = tc_pkg::tc_cnt_w(N_INSN),
  localparam int unsigned FL_W  = M_BR - 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lk_req,
  input  logic [ADDR_W-1:0]        lk_addr,
  input  logic [FL_W-1:0]          lk_pred,
  output logic                     lk_hit,
  output logic [CNT_W-1:0]         lk_count,
  output logic [N_INSN*INSN_W-1:0] lk_insns,
  output logic                     lk_ends_cond,
  output logic [ADDR_W-1:0]        lk_fallthru,
  output logic [ADDR_W-1:0]        lk_target,
  input  logic                     rt_valid,
  input  logic [INSN_W-1:0]        rt_insn,
  input  logic [ADDR_W-1:0]        rt_addr,
  input  logic                     rt_is_cond,
  input  logic                     rt_taken,
  input  logic [ADDR_W-1:0]        rt_target
);

  logic                     srst_n;
  logic                     wr_en;
  logic [IDX_W-1:0]         wr_idx;
  logic [ADDR_W-1:0]        wr_tag;
  logic [N_INSN*INSN_W-1:0] wr_insns;
  logic [CNT_W-1:0]         wr_cnt;
  logic [FL_W-1:0]          wr_mask;
  logic [FL_W-1:0]          wr_flags;
  logic                     wr_end_cond;
  logic [ADDR_W-1:0]        wr_fallthru;
  logic [ADDR_W-1:0]        wr_target;

  logic                     rd_valid;
  logic [ADDR_W-1:0]        rd_tag;
  logic [N_INSN*INSN_W-1:0] rd_insns;
  logic [CNT_W-1:0]         rd_cnt;
  logic [FL_W-1:0]          rd_mask;
  logic [FL_W-1:0]          rd_flags;
  logic                     rd_end_cond;
  logic [ADDR_W-1:0]        rd_fallthru;
  logic [ADDR_W-1:0]        rd_target;

  tc_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  tc_fill_unit #(
    .ADDR_W(ADDR_W), .INSN_W(INSN_W), .N_INSN(N_INSN), .M_BR(M_BR), .IDX_W(IDX_W)
  ) u_fill (
    .clk         (clk),
    .rst_n       (srst_n),
    .rt_valid    (rt_valid),
    .rt_insn     (rt_insn),
    .rt_addr     (rt_addr),
    .rt_is_cond  (rt_is_cond),
    .rt_taken    (rt_taken),
    .rt_target   (rt_target),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_tag      (wr_tag),
    .wr_insns    (wr_insns),
    .wr_cnt      (wr_cnt),
    .wr_mask     (wr_mask),
    .wr_flags    (wr_flags),
    .wr_end_cond (wr_end_cond),
    .wr_fallthru (wr_fallthru),
    .wr_target   (wr_target)
  );

  tc_seg_store #(
    .ADDR_W(ADDR_W), .INSN_W(INSN_W), .N_INSN(N_INSN), .M_BR(M_BR), .IDX_W(IDX_W)
  ) u_store (
    .clk         (clk),
    .rst_n       (srst_n),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_tag      (wr_tag),
    .wr_insns    (wr_insns),
    .wr_cnt      (wr_cnt),
    .wr_mask     (wr_mask),
    .wr_flags    (wr_flags),
    .wr_end_cond (wr_end_cond),
    .wr_fallthru (wr_fallthru),
    .wr_target   (wr_target),
    .rd_idx      (lk_addr[IDX_W-1:0]),
    .rd_valid    (rd_valid),
    .rd_tag      (rd_tag),
    .rd_insns    (rd_insns),
    .rd_cnt      (rd_cnt),
    .rd_mask     (rd_mask),
    .rd_flags    (rd_flags),
    .rd_end_cond (rd_end_cond),
    .rd_fallthru (rd_fallthru),
    .rd_target   (rd_target)
  );

  tc_hit_logic #(
    .ADDR_W(ADDR_W), .INSN_W(INSN_W), .N_INSN(N_INSN), .M_BR(M_BR)
  ) u_hit (
    .lk_req       (lk_req),
    .lk_addr      (lk_addr),
    .lk_pred      (lk_pred),
    .rd_valid     (rd_valid),
    .rd_tag       (rd_tag),
    .rd_insns     (rd_insns),
    .rd_cnt       (rd_cnt),
    .rd_mask      (rd_mask),
    .rd_flags     (rd_flags),
    .rd_end_cond  (rd_end_cond),
    .rd_fallthru  (rd_fallthru),
    .rd_target    (rd_target),
    .hit          (lk_hit),
    .out_cnt      (lk_count),
    .out_insns    (lk_insns),
    .out_end_cond (lk_ends_cond),
    .out_fallthru (lk_fallthru),
    .out_target   (lk_target)
  );

endmodule

// File: rtl/tc_checker.sv
module tc_checker #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned INSN_W = 32,
  parameter int unsigned N_INSN = 8,
  localparam int unsigned CNT_W = tc_pkg::tc_cnt_w(N_INSN)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     lk_req,
  input logic                     lk_hit,
  input logic [CNT_W-1:0]         lk_count,
  input logic [N_INSN*INSN_W-1:0] lk_insns,
  input logic                     lk_ends_cond,
  input logic [ADDR_W-1:0]        lk_fallthru,
  input logic [ADDR_W-1:0]        lk_target,
  input logic                     rt_valid,
  input logic                     wr_en,
  input logic [CNT_W-1:0]         wr_cnt
);

  // R11
  req_gates_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |-> !lk_hit);

  // R2
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_count == '0) && (lk_insns == '0) && !lk_ends_cond &&
                (lk_fallthru == '0) && (lk_target == '0));

  // R5
  plain_end_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && !lk_ends_cond) |-> (lk_target == lk_fallthru));

  // R3
  hit_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_count != '0) && (lk_count <= CNT_W'(N_INSN)));

  // R3
  write_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_cnt != '0) && (wr_cnt <= CNT_W'(N_INSN)));

  // R12
  write_needs_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> rt_valid);

endmodule

bind trace_seg_cache tc_checker #(
  .ADDR_W(ADDR_W), .INSN_W(INSN_W), .N_INSN(N_INSN)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lk_req       (lk_req),
  .lk_hit       (lk_hit),
  .lk_count     (lk_count),
  .lk_insns     (lk_insns),
  .lk_ends_cond (lk_ends_cond),
  .lk_fallthru  (lk_fallthru),
  .lk_target    (lk_target),
  .rt_valid     (rt_valid),
  .wr_en        (wr_en),
  .wr_cnt       (wr_cnt)
);

// File: tb/trace_seg_cache_test.sv
`timescale 1ns/1ps
module trace_seg_cache_test;

  localparam int AW = 16;
  localparam int IW = 32;
  localparam int NI = 8;
  localparam int MB = 3;
  localparam int IX = 2;
  localparam int NE = 1 << IX;
  localparam int CW = $clog2(NI + 1);

  logic           clk = 1'b0;
  logic           rst_n;
  logic           lk_req;
  logic [AW-1:0]  lk_addr;
  logic [MB-2:0]  lk_pred;
  logic           lk_hit;
  logic [CW-1:0]  lk_count;
  logic [NI*IW-1:0] lk_insns;
  logic           lk_ends_cond;
  logic [AW-1:0]  lk_fallthru;
  logic [AW-1:0]  lk_target;
  logic           rt_valid;
  logic [IW-1:0]  rt_insn;
  logic [AW-1:0]  rt_addr;
  logic           rt_is_cond;
  logic           rt_taken;
  logic [AW-1:0]  rt_target;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 0;

  always #2 clk = ~clk;

  trace_seg_cache uut (
    .clk(clk), .rst_n(rst_n),
    .lk_req(lk_req), .lk_addr(lk_addr), .lk_pred(lk_pred),
    .lk_hit(lk_hit), .lk_count(lk_count), .lk_insns(lk_insns),
    .lk_ends_cond(lk_ends_cond), .lk_fallthru(lk_fallthru), .lk_target(lk_target),
    .rt_valid(rt_valid), .rt_insn(rt_insn), .rt_addr(rt_addr),
    .rt_is_cond(rt_is_cond), .rt_taken(rt_taken), .rt_target(rt_target)
  );

  // ---------------- behavioural reference ----------------
  bit              m_v    [NE];
  logic [AW-1:0]   m_tag  [NE];
  int              m_cnt  [NE];
  logic [NI*IW-1:0] m_ins [NE];
  logic [MB-2:0]   m_mask [NE];
  logic [MB-2:0]   m_flag [NE];
  bit              m_endc [NE];
  logic [AW-1:0]   m_ft   [NE];
  logic [AW-1:0]   m_tg   [NE];

  logic [AW-1:0] q_addr [$];
  logic [IW-1:0] q_insn [$];
  bit            q_cond [$];
  bit            q_tkn  [$];

  function automatic logic [IW-1:0] word_of(input logic [AW-1:0] a);
    return 32'hC0DE_0000 | IW'(a);
  endfunction

  task automatic model_clear();
    for (int e = 0; e < NE; e++) m_v[e] = 0;
    q_addr.delete(); q_insn.delete(); q_cond.delete(); q_tkn.delete();
  endtask

  task automatic model_retire(input logic [AW-1:0] a, input bit c, input bit t,
                              input logic [AW-1:0] tgt);
    int brs;
    int e;
    int k;
    int last;
    q_addr.push_back(a); q_insn.push_back(word_of(a));
    q_cond.push_back(c); q_tkn.push_back(t);
    brs = 0;
    foreach (q_cond[j]) if (q_cond[j]) brs++;
    if (q_addr.size() == NI || brs == MB) begin
      last = q_addr.size() - 1;
      e = int'(q_addr[0]) % NE;
      m_v[e]   = 1;
      m_tag[e] = q_addr[0];
      m_cnt[e] = q_addr.size();
      m_ins[e] = '0;
      for (int j = 0; j <= last; j++) m_ins[e][j*IW +: IW] = q_insn[j];
      m_mask[e] = '0; m_flag[e] = '0; k = 0;
      for (int j = 0; j < last; j++) begin
        if (q_cond[j]) begin
          m_mask[e][k] = 1'b1;
          m_flag[e][k] = q_tkn[j];
          k++;
        end
      end
      m_endc[e] = q_cond[last];
      m_ft[e]   = q_addr[last] + 1;
      m_tg[e]   = q_cond[last] ? tgt : q_addr[last] + 1;
      q_addr.delete(); q_insn.delete(); q_cond.delete(); q_tkn.delete();
    end
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [NI*IW-1:0] act, input logic [NI*IW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    int  e;
    bit  eh;
    e  = int'(lk_addr) % NE;
    eh = lk_req && m_v[e] && (m_tag[e] == lk_addr) &&
         (((lk_pred ^ m_flag[e]) & m_mask[e]) == '0);
    chk(tag, "hit",      NI*IW'(lk_hit), NI*IW'(eh));
    chk(tag, "count",    NI*IW'(lk_count), eh ? NI*IW'(m_cnt[e]) : '0);
    chk(tag, "insns",    lk_insns, eh ? m_ins[e] : '0);
    chk(tag, "ends",     NI*IW'(lk_ends_cond), eh ? NI*IW'(m_endc[e]) : '0);
    chk(tag, "fallthru", NI*IW'(lk_fallthru), eh ? NI*IW'(m_ft[e]) : '0);
    chk(tag, "target",   NI*IW'(lk_target), eh ? NI*IW'(m_tg[e]) : '0);
  endtask

  // one clock: drive at the falling edge, compare mid-phase, then advance the model
  task automatic cyc(input string tag,
                     input bit rv, input logic [AW-1:0] ra, input bit rc, input bit rtk,
                     input logic [AW-1:0] rtg,
                     input bit req, input logic [AW-1:0] la, input logic [MB-2:0] lp,
                     input int eh);
    @(negedge clk);
    rt_valid = rv; rt_addr = ra; rt_insn = word_of(ra);
    rt_is_cond = rc; rt_taken = rtk; rt_target = rtg;
    lk_req = req; lk_addr = la; lk_pred = lp;
    #1;
    compare_all(tag);
    if (eh >= 0) chk(tag, "expected-hit", NI*IW'(lk_hit), NI*IW'(eh));
    if (rv && rst_n) model_retire(ra, rc, rtk, rtg);
  endtask

  task automatic ret(input string tag, input logic [AW-1:0] a, input bit c, input bit t,
                     input logic [AW-1:0] tgt);
    cyc(tag, 1, a, c, t, tgt, 0, '0, '0, -1);
  endtask

  task automatic look(input string tag, input logic [AW-1:0] a, input logic [MB-2:0] p,
                      input int eh);
    cyc(tag, 0, '0, 0, 0, '0, 1, a, p, eh);
  endtask

  task automatic idle(input string tag);
    cyc(tag, 0, '0, 0, 0, '0, 0, '0, '0, -1);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    rt_valid = 0; rt_addr = '0; rt_insn = '0; rt_is_cond = 0; rt_taken = 0; rt_target = '0;
    lk_req = 0; lk_addr = '0; lk_pred = '0;
    model_clear();

    // R1: lookups while reset is held
    look("R1", 16'h0010, 2'b00, 0);
    look("R1", 16'h0003, 2'b11, 0);
    @(negedge clk); rst_n = 1'b1;
    idle("R1"); idle("R1"); idle("R1");
    look("R2", 16'h0010, 2'b00, 0);

    // segment closed by instruction count, no branches: R3 R5
    for (int i = 0; i < 8; i++) begin
      if (i == 7) look("R3", 16'h0010, 2'b00, 0);
      ret("R3", 16'h0010 + AW'(i), 0, 0, '0);
    end
    look("R3", 16'h0010, 2'b00, 1);
    look("R5", 16'h0010, 2'b11, 1);

    // next segment starts right after, shares entry 0: R8 R4 R9
    ret("R8", 16'h0018, 0, 0, '0);
    ret("R4", 16'h0019, 1, 1, 16'h0040);
    ret("R4", 16'h0040, 0, 0, '0);
    ret("R4", 16'h0041, 1, 0, 16'h0070);
    ret("R4", 16'h0042, 0, 0, '0);
    ret("R4", 16'h0043, 1, 1, 16'h0080);
    look("R8", 16'h0018, 2'b01, 1);
    look("R7", 16'h0018, 2'b11, 0);
    look("R7", 16'h0018, 2'b00, 0);
    look("R7", 16'h0018, 2'b10, 0);
    look("R9", 16'h0010, 2'b00, 0);

    // one internal branch, closed by count, with idle gaps: R7 R12 R6 R11
    ret("R12", 16'h0021, 1, 1, 16'h0030);
    idle("R12");
    for (int i = 0; i < 7; i++) begin
      ret("R12", 16'h0030 + AW'(i), 0, 0, '0);
      if (i == 3) begin idle("R12"); idle("R12"); end
    end
    look("R7", 16'h0021, 2'b01, 1);
    look("R7", 16'h0021, 2'b11, 1);
    look("R7", 16'h0021, 2'b10, 0);
    look("R7", 16'h0021, 2'b00, 0);
    look("R6", 16'h0025, 2'b01, 0);
    look("R6", 16'h1021, 2'b01, 0);
    cyc("R11", 0, '0, 0, 0, '0, 0, 16'h0021, 2'b01, 0);

    // closed by count with a conditional branch last: R3 R4
    for (int i = 0; i < 7; i++) ret("R3", 16'h0052 + AW'(i), 0, 0, '0);
    ret("R3", 16'h0059, 1, 0, 16'h0090);
    look("R3", 16'h0052, 2'b00, 1);

    // read-before-write on an empty entry, then over a live one: R10
    ret("R10", 16'h0063, 1, 1, 16'h0070);
    ret("R10", 16'h0070, 1, 1, 16'h007C);
    cyc("R10", 1, 16'h007C, 1, 0, 16'h0099, 1, 16'h0063, 2'b11, 0);
    look("R10", 16'h0063, 2'b11, 1);
    ret("R10", 16'h0067, 1, 0, 16'h0001);
    ret("R10", 16'h0068, 1, 0, 16'h0002);
    cyc("R10", 1, 16'h0069, 1, 1, 16'h00A0, 1, 16'h0063, 2'b11, 1);
    look("R10", 16'h0063, 2'b11, 0);
    look("R9", 16'h0067, 2'b00, 1);

    // reset with a partly filled buffer: R1 R8
    ret("R8", 16'h0100, 0, 0, '0);
    ret("R8", 16'h0101, 0, 0, '0);
    @(negedge clk); rst_n = 1'b0;
    model_clear();
    look("R1", 16'h0067, 2'b00, 0);
    look("R1", 16'h0052, 2'b00, 0);
    @(negedge clk); rst_n = 1'b1;
    idle("R1"); idle("R1"); idle("R1");
    for (int i = 0; i < 8; i++) ret("R8", 16'h0200 + AW'(i), 0, 0, '0);
    look("R8", 16'h0200, 2'b00, 1);
    look("R1", 16'h0100, 2'b00, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule